// File: doc/BRIEF.md
# Strobe-Gated Accumulating Serial Deserializer

This block turns a single-wire serial stream into a parallel word without shifting the result register once per bit. A free-running phase counter produces a one-clock sample strobe once per bit period. An accumulator adds a one-hot weight word on every clock where that strobe and the serial line are both high. After each sample the weight moves to a new position, so each received bit is written into a chosen bit of the result. Because the weight has one set bit and never visits the same position twice in a word, each addition acts as an OR and no carry can occur.

A word begins with a start marker, a high pulse about one and a half bit periods long. On the rising edge of the synchronized line the block realigns the strobe phase so that every later strobe lands near the centre of a data bit. It also clears the accumulator. After the configured number of bits it clears the weight, pulses `data_valid` for one clock and waits for the next start edge. Resynchronizing once per word is enough to absorb the small frequency error between two independent crystal clocks. The placement order is a parameter. The default order fills the word one byte at a time, least significant byte first and most significant bit first within each byte. Two plain orders, MSB-first and LSB-first, are also available.

Top module: `accum_deser`

## Requirements
- R1: After reset, `data_valid` is 0 and `data_out` is 0, and both stay so while the line is idle low.
- R2: With the defaults (SYNC_STAGES=2, FIRST_DELAY=8, 4-clock bit period), take the first clock on which the pin is high as clock 0 and a 6-clock start marker. The pin value on clock 8+4*i is then taken as data bit i. Bit i occupies clocks 6+4*i to 9+4*i.
- R3: In the default order (ORDER=0), bit i is written to data position 8*(i/8) + 7 - (i mod 8). The first byte fills bits 7..0 with its first bit at bit 7, the next byte fills 15..8, and so on.
- R4: With ORDER=1, bit i is written to position NBITS-1-i. With ORDER=2, bit i is written to position i.
- R5: Every start edge clears the accumulator. Positions that receive a 0 bit, or that no bit reaches, read 0, and nothing from an earlier word survives.
- R6: `data_valid` is high for exactly one clock, on pin clock 4*NBITS+7 counted as in R2. On that clock `data_out` holds the finished word, and it still holds it on the following clock.
- R7: Rising edges of the line while a word is being collected do not restart collection, and they do not produce an early `data_valid`.
- R8: The strobe phase is realigned on every start edge. Start markers of 5, 6 or 7 clocks all decode correctly, with `data_valid` timed from the marker's rising edge.
- R9: With NBITS below the data width, collection stops after NBITS bits, all higher positions read 0, and the block accepts the next word after the line has been low for one clock.
- R10: The sample strobe is high for exactly one clock in every four. Outside the realignment at a start edge, successive strobes are exactly four clocks apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| serial_in | input | 1 | Serial line, idle low, asynchronous to clk |
| data_out | output | DATA_W | Assembled word, valid while data_valid is high |
| data_valid | output | 1 | One-clock pulse when a word is complete |

## Verification
A weight that is stuck, duplicated or stepped wrongly puts a bit in the wrong place or drops it. That shows up in `data_out` at the next `data_valid`, one word period after the fault. Walking-one and walking-zero words therefore pin down every placement position in each order. A strobe phase that is off by one or two clocks samples the edges of bits instead of their centres. Start markers of 5 and 7 clocks turn such an error into a wrong word at once. A bit counter or state error moves the `data_valid` clock or leaves stale bits in the accumulator, and both are visible on the first word after the fault.

// File: rtl/accum_deser_pkg.sv
package accum_deser_pkg;

   typedef enum logic [1:0] {
      ST_ARM  = 2'd0,
      ST_LEAD = 2'd1,
      ST_RUN  = 2'd2
   } ds_state_e;

   localparam int ORD_GROUPED   = 0;
   localparam int ORD_MSB_FIRST = 1;
   localparam int ORD_LSB_FIRST = 2;

endpackage

// File: rtl/accum_deser_sync.sv
// Input synchronizer plus rising-edge detector on the synchronized line.
module accum_deser_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic line_i,
   output logic line_o,
   output logic rise_o
);

   logic line_q;

   generate
      if (STAGES == 0) begin : g_direct
         assign line_o = line_i;
      end else begin : g_chain
         logic [STAGES-1:0] chain_q;
         always_ff @(posedge clk) begin
            if (!rst_n) chain_q <= '0;
            else        chain_q <= (chain_q << 1) | STAGES'(line_i);
         end
         assign line_o = chain_q[STAGES-1];
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) line_q <= 1'b0;
      else        line_q <= line_o;
   end

   assign rise_o = line_o & ~line_q;

endmodule

// File: rtl/accum_deser_phase.sv
// Free-running phase counter; strobe on the last phase of each period.
module accum_deser_phase #(
   parameter int PERIOD_LOG2 = 2,
   parameter int LOAD_VAL    = 0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic load_i,
   output logic strobe_o
);

   logic [PERIOD_LOG2-1:0] ph_q;

   always_ff @(posedge clk) begin
      if (!rst_n)      ph_q <= '0;
      else if (load_i) ph_q <= PERIOD_LOG2'(LOAD_VAL);
      else             ph_q <= ph_q + 1'b1;
   end

   assign strobe_o = &ph_q;

endmodule

// File: rtl/accum_deser_weight.sv
// One-hot placement weight; the ORDER parameter picks the walk sequence.
module accum_deser_weight
   import accum_deser_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int NBITS  = 32,
   parameter int GROUP  = 8,
   parameter int ORDER  = ORD_GROUPED
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_i,
   input  logic              step_i,
   input  logic              clear_i,
   output logic [DATA_W-1:0] weight_o
);

   logic [DATA_W-1:0] weight_q;
   logic [DATA_W-1:0] start_w;
   logic [DATA_W-1:0] next_w;

   generate
      if (ORDER == ORD_GROUPED) begin : g_grouped
         localparam int NG = DATA_W / GROUP;
         logic [NG-1:0] at_floor;
         for (genvar g = 0; g < NG; g++) begin : g_floor
            assign at_floor[g] = weight_q[g*GROUP];
         end
         assign start_w = DATA_W'(1) << (GROUP - 1);
         // bottom of a group: jump to the top of the next group
         assign next_w  = (|at_floor) ? (weight_q << (2*GROUP - 1))
                                      : (weight_q >> 1);
      end else if (ORDER == ORD_MSB_FIRST) begin : g_msb
         assign start_w = DATA_W'(1) << (NBITS - 1);
         assign next_w  = weight_q >> 1;
      end else begin : g_lsb
         assign start_w = DATA_W'(1);
         assign next_w  = weight_q << 1;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)       weight_q <= '0;
      else if (clear_i) weight_q <= '0;
      else if (load_i)  weight_q <= start_w;
      else if (step_i)  weight_q <= next_w;
   end

   assign weight_o = weight_q;

endmodule

// File: rtl/accum_deser_acc.sv
// Accumulator: adds the weight on gated strobes, cleared at a start edge.
module accum_deser_acc #(
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear_i,
   input  logic              add_i,
   input  logic [DATA_W-1:0] weight_i,
   output logic [DATA_W-1:0] acc_o
);

   logic [DATA_W-1:0] acc_q;

   always_ff @(posedge clk) begin
      if (!rst_n)       acc_q <= '0;
      else if (clear_i) acc_q <= '0;
      else if (add_i)   acc_q <= acc_q + weight_i;
   end

   assign acc_o = acc_q;

endmodule

// File: rtl/accum_deser.sv
module accum_deser
   import accum_deser_pkg::*;
#(
   parameter int DATA_W      = 32,
   parameter int NBITS       = 32,
   parameter int GROUP       = 8,
   parameter int ORDER       = ORD_GROUPED,
   parameter int PERIOD_LOG2 = 2,
   parameter int FIRST_DELAY = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              serial_in,
   output logic [DATA_W-1:0] data_out,
   output logic              data_valid
);

   localparam int PERIOD  = 1 << PERIOD_LOG2;
   localparam int PH_LOAD = (PERIOD - (FIRST_DELAY % PERIOD)) % PERIOD;
   localparam int LEAD_W  = $clog2(FIRST_DELAY + 1);
   localparam int CNT_W   = $clog2(NBITS + 1);

   generate
      if (NBITS < 1 || NBITS > DATA_W) begin : g_bad_nbits
         $error("NBITS must lie in 1..DATA_W");
      end
      if (ORDER == ORD_GROUPED && (GROUP < 1 || DATA_W % GROUP != 0)) begin : g_bad_group
         $error("GROUP must divide DATA_W in grouped order");
      end
      if (ORDER < ORD_GROUPED || ORDER > ORD_LSB_FIRST) begin : g_bad_order
         $error("ORDER out of range");
      end
      if (FIRST_DELAY < 2) begin : g_bad_delay
         $error("FIRST_DELAY must be at least 2");
      end
      if (PERIOD_LOG2 < 1) begin : g_bad_period
         $error("PERIOD_LOG2 must be at least 1");
      end
      if (SYNC_STAGES < 0 || SYNC_STAGES > 4) begin : g_bad_sync
         $error("SYNC_STAGES must lie in 0..4");
      end
   endgenerate

   logic              line_s;
   logic              rise;
   logic              strobe;
   logic [DATA_W-1:0] weight;

   ds_state_e         state_q;
   logic [LEAD_W-1:0] lead_q;
   logic [CNT_W-1:0]  cnt_q;
   logic              valid_q;

   logic start;
   logic enter_run;
   logic run_strobe;
   logic last;

   assign start      = (state_q == ST_ARM) && rise;
   assign enter_run  = (state_q == ST_LEAD) && (lead_q == LEAD_W'(1));
   assign run_strobe = (state_q == ST_RUN) && strobe;
   assign last       = run_strobe && (cnt_q == CNT_W'(NBITS - 1));

   accum_deser_sync #(
      .STAGES (SYNC_STAGES)
   ) u_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .line_i (serial_in),
      .line_o (line_s),
      .rise_o (rise)
   );

   accum_deser_phase #(
      .PERIOD_LOG2 (PERIOD_LOG2),
      .LOAD_VAL    (PH_LOAD)
   ) u_phase (
      .clk      (clk),
      .rst_n    (rst_n),
      .load_i   (start),
      .strobe_o (strobe)
   );

   accum_deser_weight #(
      .DATA_W (DATA_W),
      .NBITS  (NBITS),
      .GROUP  (GROUP),
      .ORDER  (ORDER)
   ) u_weight (
      .clk      (clk),
      .rst_n    (rst_n),
      .load_i   (enter_run),
      .step_i   (run_strobe && !last),
      .clear_i  (last),
      .weight_o (weight)
   );

   accum_deser_acc #(
      .DATA_W (DATA_W)
   ) u_acc (
      .clk      (clk),
      .rst_n    (rst_n),
      .clear_i  (start),
      .add_i    (strobe && line_s),
      .weight_i (weight),
      .acc_o    (data_out)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_ARM;
         lead_q  <= '0;
         cnt_q   <= '0;
         valid_q <= 1'b0;
      end else begin
         valid_q <= last;
         case (state_q)
            ST_ARM: begin
               if (rise) begin
                  state_q <= ST_LEAD;
                  lead_q  <= LEAD_W'(FIRST_DELAY - 1);
               end
            end
            ST_LEAD: begin
               if (lead_q == LEAD_W'(1)) begin
                  state_q <= ST_RUN;
                  cnt_q   <= '0;
               end else begin
                  lead_q <= lead_q - 1'b1;
               end
            end
            ST_RUN: begin
               if (strobe) begin
                  if (last) state_q <= ST_ARM;
                  else      cnt_q   <= cnt_q + 1'b1;
               end
            end
            default: state_q <= ST_ARM;
         endcase
      end
   end

   assign data_valid = valid_q;

endmodule

// File: rtl/accum_deser_chk.sv
module accum_deser_chk
   import accum_deser_pkg::*;
#(
   parameter int DATA_W      = 32,
   parameter int NBITS       = 32,
   parameter int PERIOD_LOG2 = 2
) (
   input logic                     clk,
   input logic                     rst_n,
   input ds_state_e                state_i,
   input logic                     strobe_i,
   input logic                     load_i,
   input logic                     line_i,
   input logic [DATA_W-1:0]        weight_i,
   input logic [DATA_W-1:0]        acc_i,
   input logic [$clog2(NBITS+1)-1:0] cnt_i,
   input logic                     valid_i
);

   localparam int PERIOD = 1 << PERIOD_LOG2;

   logic [PERIOD_LOG2-1:0] gap_q;
   logic                   fresh_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         gap_q   <= '0;
         fresh_q <= 1'b0;
      end else begin
         gap_q <= (strobe_i || load_i) ? '0 : gap_q + 1'b1;
         if (load_i)        fresh_q <= 1'b1;
         else if (strobe_i) fresh_q <= 1'b0;
      end
   end

   a_r10_strobe_gap: assert property (@(posedge clk) disable iff (!rst_n)
      (strobe_i && !fresh_q) |-> (gap_q == PERIOD_LOG2'(PERIOD - 1)));

   a_r10_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
      strobe_i |=> !strobe_i);

   a_r3_weight_onehot: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(weight_i));

   a_r5_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
      (strobe_i && line_i) |-> ((acc_i & weight_i) == '0));

   a_r5_cleared_at_start: assert property (@(posedge clk) disable iff (!rst_n)
      (state_i == ST_LEAD && $past(state_i) == ST_ARM) |-> (acc_i == '0));

   a_r2_lead_no_weight: assert property (@(posedge clk) disable iff (!rst_n)
      (state_i == ST_LEAD) |-> (weight_i == '0));

   a_r6_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      valid_i |=> !valid_i);

   a_r6_valid_after_run: assert property (@(posedge clk) disable iff (!rst_n)
      valid_i |-> ($past(state_i) == ST_RUN && state_i == ST_ARM));

   a_r9_cnt_range: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_i < ($clog2(NBITS+1))'(NBITS));

endmodule

bind accum_deser accum_deser_chk #(
   .DATA_W      (DATA_W),
   .NBITS       (NBITS),
   .PERIOD_LOG2 (PERIOD_LOG2)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .state_i  (state_q),
   .strobe_i (strobe),
   .load_i   (start),
   .line_i   (line_s),
   .weight_i (weight),
   .acc_i    (data_out),
   .cnt_i    (cnt_q),
   .valid_i  (data_valid)
);

// File: tb/accum_deser_bench.sv
`timescale 1ns/1ps
module accum_deser_bench;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic din = 1'b0;
   logic din_s = 1'b0;

   logic [31:0] d_grp, d_msb, d_lsb, d_sh;
   logic        v_grp, v_msb, v_lsb, v_sh;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #2.5 clk = ~clk;

   accum_deser u_accum_deser (.clk(clk), .rst_n(rst_n), .serial_in(din),
                              .data_out(d_grp), .data_valid(v_grp));
   accum_deser #(.ORDER(1)) u_msb (.clk(clk), .rst_n(rst_n), .serial_in(din),
                              .data_out(d_msb), .data_valid(v_msb));
   accum_deser #(.ORDER(2)) u_lsb (.clk(clk), .rst_n(rst_n), .serial_in(din),
                              .data_out(d_lsb), .data_valid(v_lsb));
   accum_deser #(.NBITS(12)) u_short (.clk(clk), .rst_n(rst_n), .serial_in(din_s),
                              .data_out(d_sh), .data_valid(v_sh));

   task automatic check(input bit ok, input string tag,
                        input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic int pos_of(input int ord, input int n, input int i);
      if (ord == 0)      return (i / 8) * 8 + 7 - (i % 8);
      else if (ord == 1) return n - 1 - i;
      else               return i;
   endfunction

   function automatic logic [31:0] place(input int ord, input int n,
                                         input logic [31:0] bits);
      logic [31:0] r = '0;
      for (int i = 0; i < n; i++) r[pos_of(ord, n, i)] = bits[i];
      return r;
   endfunction

   // bits[i] is sent as the i-th data bit; mlen is the marker length
   task automatic frame(input logic [31:0] bits, input int n, input int mlen,
                        input bit short_sel, input string tag);
      logic [31:0] held;
      for (int k = 0; k <= 4*n + 9; k++) begin
         logic v;
         @(negedge clk);
         if (short_sel) begin
            if (k < 4*n + 7) check(v_sh == 1'b0, {tag, " R7 early valid"}, 32'(v_sh), 0);
            if (k == 4*n + 7) begin
               check(v_sh == 1'b1, {tag, " R6 valid"}, 32'(v_sh), 1);
               check(d_sh == place(0, n, bits), {tag, " R9 data"}, d_sh, place(0, n, bits));
               held = d_sh;
            end
            if (k == 4*n + 8) begin
               check(v_sh == 1'b0, {tag, " R6 one clock"}, 32'(v_sh), 0);
               check(d_sh == held, {tag, " R6 hold"}, d_sh, held);
            end
         end else begin
            if (k < 4*n + 7) check(v_grp == 1'b0, {tag, " R7 early valid"}, 32'(v_grp), 0);
            if (k == 4*n + 7) begin
               check(v_grp && v_msb && v_lsb, {tag, " R6 valid"},
                     {29'd0, v_grp, v_msb, v_lsb}, 32'd7);
               check(d_grp == place(0, n, bits), {tag, " R3 R2 R10 grouped"},
                     d_grp, place(0, n, bits));
               check(d_msb == place(1, n, bits), {tag, " R4 msb-first"},
                     d_msb, place(1, n, bits));
               check(d_lsb == place(2, n, bits), {tag, " R4 lsb-first"},
                     d_lsb, place(2, n, bits));
               held = d_grp;
            end
            if (k == 4*n + 8) begin
               check(v_grp == 1'b0, {tag, " R6 one clock"}, 32'(v_grp), 0);
               check(d_grp == held, {tag, " R6 hold"}, d_grp, held);
            end
         end
         if (k < mlen)             v = 1'b1;
         else if (k < mlen + 4*n)  v = bits[(k - mlen) / 4];
         else                      v = 1'b0;
         if (short_sel) din_s = v;
         else           din   = v;
      end
   endtask

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      repeat (6) @(negedge clk);
      check(!v_grp && !v_msb && !v_lsb && !v_sh, "R1 valid after reset",
            {28'd0, v_grp, v_msb, v_lsb, v_sh}, 0);
      check((d_grp | d_msb | d_lsb | d_sh) == '0, "R1 data after reset",
            d_grp | d_msb | d_lsb | d_sh, 0);

      frame(32'hFFFF_FFFF, 32, 6, 1'b0, "ones");
      frame(32'h0000_0000, 32, 6, 1'b0, "R5 zeros after ones");
      frame(32'h5555_5555, 32, 6, 1'b0, "R7 alternating");
      for (int i = 0; i < 32; i++) frame(32'h1 << i, 32, 6, 1'b0, "walk1");
      for (int i = 0; i < 32; i++) frame(~(32'h1 << i), 32, 6, 1'b0, "walk0");
      frame(32'hA5C3_0F81, 32, 5, 1'b0, "R8 marker5");
      frame(32'h1234_5678, 32, 7, 1'b0, "R8 marker7");
      frame(32'h8000_0001, 32, 7, 1'b0, "R8 marker7 edges");
      frame(32'h0F0F_33CC, 32, 5, 1'b0, "R8 marker5 mix");

      frame(32'h0000_0FFF, 12, 6, 1'b1, "short ones");
      frame(32'hFFFF_FA5B, 12, 6, 1'b1, "R9 short mixed");
      frame(32'h0000_0000, 12, 6, 1'b1, "R5 short zeros");
      frame(32'h0000_0C35, 12, 5, 1'b1, "R8 short marker5");

      repeat (4) @(negedge clk);
      check(!v_grp && !v_sh, "R1 idle tail", {30'd0, v_grp, v_sh}, 0);

      if (!done) begin
         done = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++;
         fails++;
         $display("FAIL watchdog expired actual=%h expected=%h", 32'd1, 32'd0);
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

endmodule